// File: doc/BRIEF.md
# Convergent Rounding Right Shifter

This block divides a signed integer by a power of two and rounds the quotient to the nearest integer. A result that lies exactly halfway between two integers goes to the even one. Each accepted operand carries a shift amount `n` from 0 to `IN_W-1`. The operand is widened to twice its width by copying its sign bit, so that adding the rounding bias can never overflow. The bias depends on the bits below the halfway position:

- If those bits are all zero, the bias is the operand's bit `n` moved down one place, so a tie rounds up only when the integer part is odd.
- Otherwise the bias is a plain `2^(n-1)`.

The biased sum is shifted right arithmetically by `n` and clamped to the signed range of the output. A shift of zero passes the operand through untouched.

The result is registered, so it appears one cycle after the operand is offered. A sticky flag records whether any result ever had to be clamped. With the default widths (32-bit input, 32-bit output) no legal operand can be clamped. A narrower `OUT_W` makes clamping reachable, and the same logic then saturates.

Top module: `crs_round_shift`

## Requirements
- R1: When `shamt` is 0, the result equals the input operand unchanged (for example 0x12345678 stays 0x12345678).
- R2: When the discarded fraction is below one half the quotient rounds down, and above one half it rounds up (19>>3 gives 2, 21>>3 gives 3).
- R3: When the discarded fraction is exactly one half, the result is the even neighbour: 20>>3 gives 2, 12>>3 gives 2, 5>>1 gives 2, 7>>1 gives 4.
- R4: Negative operands, taken as two's complement, follow the same nearest-with-ties-to-even rule: -5>>1 gives -2, -7>>1 gives -4, -1>>1 gives 0.
- R5: Every shift amount from 1 to 31 rounds correctly, including the extremes. At 31, 0x40000000 and 0xC0000000 give 0, 0x7FFFFFFF gives 1 and 0x80000000 gives -1. At 1, 0x7FFFFFFF gives 0x40000000.
- R6: `dout` and `out_valid` update on the rising edge after `in_valid` is sampled high. `out_valid` is low in any cycle that follows a cycle with `in_valid` low.
- R7: A rounded value above the signed `OUT_W` range becomes the largest positive value, and one below it becomes the most negative value. With `OUT_W` equal to `IN_W` this never happens.
- R8: `sat_flag` goes high in the cycle a clamped result is delivered and stays high until reset.
- R9: A synchronous active-low reset clears `out_valid`, `dout` and `sat_flag` to 0.
- R10: While `in_valid` is low, `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and shift amount are valid this cycle |
| din | input | IN_W | Signed operand, two's complement |
| shamt | input | $clog2(IN_W) | Right-shift amount n |
| out_valid | output | 1 | `dout` carries a new result |
| dout | output | OUT_W | Rounded, clamped quotient |
| sat_flag | output | 1 | Sticky: some result was clamped |

## Verification
Two situations are hard to reach from the ports.

The first is an exact tie. It needs a residue of precisely `10…0` below the shift point, and random operands almost never produce one. The stimulus therefore builds ties on purpose, with both odd and even integer parts, positive and negative signs, and at `n` of 1 and 31.

The second is clamping, which cannot happen at the default widths. The bench therefore drives a second instance with a 16-bit output from the same operands. That instance reaches both clamp limits, and the bench then checks that its flag stays set after later results that fit.

// File: rtl/crs_pkg.sv
// Shared types for the convergent rounding right shifter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package crs_pkg;

    // Which clamp, if any, the shift/clamp stage applied to a result.
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HI   = 2'd1,
        CLAMP_LO   = 2'd2
    } clamp_e;

endpackage

// File: rtl/crs_bias_gen.sv
// Rounding bias generator.
// Works out the constant to add before the right shift so that the shift
// gives round-to-nearest with ties to even.
// Assumes: ext is the operand already sign-extended to EXT_W bits, and
// shamt < EXT_W. A zero shift yields zero bias.
module crs_bias_gen #(
    parameter int EXT_W = 64,
    parameter int SH_W  = 5
) (
    input  logic [EXT_W-1:0] ext,
    input  logic [SH_W-1:0]  shamt,
    output logic [EXT_W-1:0] bias
);

    logic [EXT_W-1:0] half;      // weight of the halfway bit, 2^(n-1)
    logic [EXT_W-1:0] low_mask;  // bits strictly below the halfway bit
    logic             low_clear; // those bits are all zero

    // Locate the halfway bit and the bits beneath it.
    always_comb begin
        if (shamt == '0) begin
            half = '0;
        end else begin
            half = EXT_W'(1) << (shamt - SH_W'(1));
        end
        low_mask  = half - EXT_W'(1);
        low_clear = ((ext & low_mask) == '0);
    end

    // Choose the bias: move bit n down on a possible tie, else add one half.
    always_comb begin
        if (shamt == '0) begin
            bias = '0;
        end else if (low_clear) begin
            bias = (ext >> 1) & half;
        end else begin
            bias = half;
        end
    end

endmodule

// File: rtl/crs_shift_sat.sv
// Add, arithmetic shift and clamp stage.
// Adds the rounding bias to the widened operand, shifts the sum right
// arithmetically by shamt, and clamps it to the signed OUT_W range.
// Assumes: EXT_W is wide enough that ext + bias never overflows, and
// OUT_W < EXT_W.
module crs_shift_sat
    import crs_pkg::*;
#(
    parameter int EXT_W = 64,
    parameter int OUT_W = 32,
    parameter int SH_W  = 5
) (
    input  logic [EXT_W-1:0] ext,
    input  logic [EXT_W-1:0] bias,
    input  logic [SH_W-1:0]  shamt,
    output logic [OUT_W-1:0] res,
    output logic             sat_hit
);

    localparam logic signed [EXT_W-1:0] MAXV =
        {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MINV = ~MAXV;

    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shifted;
    clamp_e                  clamp;

    // Biased sum, then arithmetic right shift by n.
    always_comb begin
        sum     = $signed(ext) + $signed(bias);
        shifted = sum >>> shamt;
    end

    // Range check against the signed output limits.
    always_comb begin
        if (shifted > MAXV) begin
            clamp = CLAMP_HI;
        end else if (shifted < MINV) begin
            clamp = CLAMP_LO;
        end else begin
            clamp = CLAMP_NONE;
        end
    end

    // Output selection and clamp indication.
    always_comb begin
        unique case (clamp)
            CLAMP_HI: res = MAXV[OUT_W-1:0];
            CLAMP_LO: res = MINV[OUT_W-1:0];
            default:  res = shifted[OUT_W-1:0];
        endcase
        sat_hit = (clamp != CLAMP_NONE);
    end

endmodule

// File: rtl/crs_round_shift.sv
// Convergent rounding right shifter, top level.
// Registers the rounded, clamped quotient din / 2^shamt one cycle after
// in_valid and keeps a sticky flag of clamp events.
// Assumes: synchronous active-low reset; din is two's complement.
module crs_round_shift #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 32,
    localparam int SH_W = $clog2(IN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  din,
    input  logic [SH_W-1:0]  shamt,
    output logic             out_valid,
    output logic [OUT_W-1:0] dout,
    output logic             sat_flag
);

    localparam int EXT_W = 2 * IN_W;
    localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OUT_MIN = ~OUT_MAX;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] bias_w;
    logic [OUT_W-1:0] res_w;
    logic             sat_hit;

    // Widen the operand by copying its sign bit.
    always_comb begin
        ext = {{IN_W{din[IN_W-1]}}, din};
    end

    crs_bias_gen #(
        .EXT_W (EXT_W),
        .SH_W  (SH_W)
    ) bias_i (
        .ext   (ext),
        .shamt (shamt),
        .bias  (bias_w)
    );

    crs_shift_sat #(
        .EXT_W (EXT_W),
        .OUT_W (OUT_W),
        .SH_W  (SH_W)
    ) shsat_i (
        .ext     (ext),
        .bias    (bias_w),
        .shamt   (shamt),
        .res     (res_w),
        .sat_hit (sat_hit)
    );

    // Output register: capture a result whenever an operand is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dout <= res_w;
            end
        end
    end

    // Sticky clamp flag: sets on any clamped result, clears only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_flag <= 1'b0;
        end else if (in_valid && sat_hit) begin
            sat_flag <= 1'b1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dout)); // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |=> sat_flag); // R8
    AST_BIAS_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bias_w)); // R3
    AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sat_hit |=> (dout == OUT_MAX) || (dout == OUT_MIN)); // R7

    generate
        if (OUT_W == IN_W) begin : g_full_width
            AST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && (shamt == '0) |=> dout == $past(din)); // R1
            AST_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> !sat_hit); // R7
        end
    endgenerate

endmodule

// File: tb/crs_round_shift_tb_top.sv
// Self-checking bench for crs_round_shift: a vector table, an exhaustive
// shift sweep, then directed reset, hold and clamp tests.
module crs_round_shift_tb_top;

    localparam int  NT      = 16;
    localparam time HALF_CK = 2.5ns;

    localparam logic [31:0] TV_DIN [NT] = '{
        32'd5, 32'd7, 32'hFFFF_FFFB, 32'hFFFF_FFF9,
        32'd12, 32'd20, 32'd21, 32'd19,
        32'h1234_5678, 32'h4000_0000, 32'hC000_0000, 32'h7FFF_FFFF,
        32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF
    };
    localparam int TV_N [NT] = '{1, 1, 1, 1, 3, 3, 3, 3, 0, 31, 31, 31, 31, 1, 1, 31};
    localparam logic [31:0] TV_EXP [NT] = '{
        32'd2, 32'd4, 32'hFFFF_FFFE, 32'hFFFF_FFFC,
        32'd2, 32'd2, 32'd3, 32'd2,
        32'h1234_5678, 32'd0, 32'd0, 32'd1,
        32'hFFFF_FFFF, 32'h4000_0000, 32'd0, 32'd0
    };
    localparam string TV_TAG [NT] = '{
        "R3", "R3", "R4", "R4", "R3", "R3", "R2", "R2",
        "R1", "R5", "R5", "R5", "R5", "R5", "R4", "R4"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] din = '0;
    logic [4:0]  shamt = '0;
    logic        ov_w, sf_w, ov_n, sf_n;
    logic [31:0] dout_w;
    logic [15:0] dout_n;

    int  total = 0;
    int  bad = 0;
    bit  exp_sf_n = 1'b0;
    bit  finished = 1'b0;

    always #HALF_CK clk = ~clk;

    crs_round_shift dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din), .shamt(shamt),
        .out_valid(ov_w), .dout(dout_w), .sat_flag(sf_w)
    );

    crs_round_shift #(.IN_W(32), .OUT_W(16)) dut_n_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din), .shamt(shamt),
        .out_valid(ov_n), .dout(dout_n), .sat_flag(sf_n)
    );

    // Independent model: floor quotient plus remainder comparison.
    function automatic longint model_raw(input logic [31:0] a, input int n);
        longint v = longint'($signed(a));
        longint q, r, h;
        if (n == 0) return v;
        q = v >>> n;
        r = v - (q <<< n);
        h = longint'(1) <<< (n - 1);
        if (r > h || (r == h && q[0])) q = q + 1;
        return q;
    endfunction

    function automatic longint clamp_to(input longint v, input int w);
        longint mx = (longint'(1) <<< (w - 1)) - 1;
        longint mn = -(longint'(1) <<< (w - 1));
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Drive one operand, wait for the registered result, check both widths.
    task automatic apply(input logic [31:0] a, input int n, input string tag);
        longint raw, ew, en;
        @(negedge clk);
        in_valid = 1'b1;
        din      = a;
        shamt    = 5'(n);
        raw = model_raw(a, n);
        ew  = clamp_to(raw, 32);
        en  = clamp_to(raw, 16);
        if (en != raw) exp_sf_n = 1'b1;
        @(posedge clk);
        #1;
        chk(longint'($signed(dout_w)) == ew, tag, longint'($signed(dout_w)), ew);
        chk(longint'($signed(dout_n)) == en, {tag, "/R7 narrow"}, longint'($signed(dout_n)), en);
        chk(ov_w == 1'b1, "R6 out_valid", longint'(ov_w), 1);
        chk(sf_n == exp_sf_n, "R8 narrow flag", longint'(sf_n), longint'(exp_sf_n));
    endtask

    initial begin
        // R9: reset with active inputs
        in_valid = 1'b1;
        din      = 32'h7FFF_FFFF;
        shamt    = 5'd0;
        repeat (3) @(posedge clk);
        #1;
        chk(ov_w == 1'b0 && ov_n == 1'b0, "R9 out_valid", longint'(ov_w), 0);
        chk(dout_w == '0 && dout_n == '0, "R9 dout", longint'(dout_w), 0);
        chk(sf_w == 1'b0 && sf_n == 1'b0, "R9 sat_flag", longint'(sf_n), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Vector table against hand-worked results
        for (int i = 0; i < NT; i++) begin
            apply(TV_DIN[i], TV_N[i], TV_TAG[i]);
            chk(dout_w == TV_EXP[i], {TV_TAG[i], " table"}, longint'($signed(dout_w)),
                longint'($signed(TV_EXP[i])));
        end

        // R5: every shift with tie, near-tie and sign patterns (R2 R3 R4)
        for (int n = 0; n < 32; n++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] a;
                case (k)
                    0: a = (32'd3 << n) >> 1;
                    1: a = (32'd5 << n) >> 1;
                    2: a = ((32'd5 << n) >> 1) + 32'd1;
                    3: a = 32'd0 - ((32'd3 << n) >> 1);
                    4: a = 32'hA5C3_0F96;
                    default: a = 32'h8000_0001;
                endcase
                apply(a, n, "R5 sweep");
            end
        end

        // R10: dout holds and out_valid drops while in_valid is low
        apply(32'd21, 3, "R2");
        @(negedge clk);
        in_valid = 1'b0;
        din      = 32'h5555_5555;
        shamt    = 5'd0;
        @(posedge clk);
        #1;
        chk(dout_w == 32'd3, "R10 hold", longint'(dout_w), 3);
        chk(ov_w == 1'b0, "R6 idle", longint'(ov_w), 0);

        // R7/R8: narrow clamps high then low, flag sticks
        apply(32'h7FFF_FFFF, 0, "R7 high");
        chk(dout_n == 16'h7FFF, "R7 clamp high", longint'(dout_n), 32767);
        apply(32'h8000_0000, 4, "R7 low");
        chk(dout_n == 16'h8000, "R7 clamp low", longint'(dout_n), 32768);
        apply(32'd20, 3, "R8 after");
        chk(sf_n == 1'b1, "R8 sticky", longint'(sf_n), 1);
        chk(sf_w == 1'b0, "R7 wide never clamps", longint'(sf_w), 0);

        @(negedge clk);
        in_valid = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule